// File: doc/BRIEF.md
# Two-Stage Sigma-Delta Decimation Chain

This block turns the one-bit, high-rate stream of a sigma-delta modulator into signed conversion words. Stage one is a third-order sinc (sinc3) decimator whose decimation ratio is set at run time. It sets both how often results appear and the bandwidth of the result. Stage two is a fixed, symmetric 22-tap FIR low-pass that runs on the decimated samples. A bypass control takes the FIR out of the path, so that the sinc3 sample becomes the result.

Two further modes shape the response. In step-tracking mode, a new sample that differs from the last result by more than a set threshold is taken as a step. The block then supplies results from a short moving average instead of the FIR, and keeps doing so until the FIR delay line holds 22 samples taken since that step. In chop mode, the block flips a polarity output on every sinc3 sample. The front end uses that output to reverse its input. The block then turns each pair of opposite-polarity samples into one half-difference, which removes any offset common to both samples.

Top module: `dec2_chain`

## Requirements
- R1: Each modulator bit counts as +1 (bit 1) or -1 (bit 0) on a strobe of `bit_vld`. With the input settled, a sinc3 sample is R*R*R times the mean of the last R counts (R = `dec_ratio`). So all ones give +R^3, all zeros give -R^3, a repeating run of seven ones then one zero gives 6*R*R when R = 8, and alternating bits give 0 when R is even.
- R2: `dec_ratio` may be 2 to 255. With `bit_vld` held high and chop off, results come exactly `dec_ratio` clock cycles apart.
- R3: With the bypass off and no step tracking, the result is the 22-tap FIR of the sinc3 samples. The FIR has unity DC gain, so a settled input gives exactly the sinc3 value. After an input step, the fifth result still lies on the side of the old level, and the 30th result equals the new level.
- R4: With `skip_en` high, each result is the sinc3 sample (after the chop step when chop is on). A full-scale step therefore reaches its new value exactly by the sixth result.
- R5: With `fast_en` high and `skip_en` low, a sample that differs from the previous result by more than `step_thr` starts short-filter operation. `fast_active` is high together with every result that comes from the short filter. When `skip_en` is high or `fast_en` is low, `fast_active` falls on the next clock.
- R6: The short filter is the mean of the newest 1, 2, 3 and then 4 samples since the step, rounded toward zero. A settled new level therefore comes out exactly.
- R7: A step sample counts as number 1. Samples 1 to 21 after the last step come from the short filter, and sample 22 onward come from the FIR again. One step gives a run of at least 21 results with `fast_active` set.
- R8: Changes that never exceed `step_thr` leave `fast_active` low.
- R9: With `chop_en` high, `chop_pol` toggles on every sinc3 sample and stays low while chop is off. A sample taken while `chop_pol` is 0 is held. The next sample, taken while `chop_pol` is 1, yields (held - new) shifted right arithmetically by one. Results therefore come every 2R cycles, and a constant offset cancels to 0.
- R10: `res_data` is 24-bit two's complement and saturates at +8388607 and -8388608.
- R11: `res_valid` is a single-cycle pulse for each new result, and `res_data` does not change between pulses.
- R12: Synchronous reset clears `res_valid`, `res_data`, `fast_active` and `chop_pol` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe marking a valid modulator bit |
| bit_in | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| dec_ratio | input | 8 | Sinc3 decimation ratio R, 2 to 255 |
| skip_en | input | 1 | Bypass the FIR stage |
| fast_en | input | 1 | Enable step tracking with the short filter |
| chop_en | input | 1 | Enable chopped operation |
| step_thr | input | 24 | Step threshold, unsigned |
| chop_pol | output | 1 | Input polarity request to the front end |
| res_valid | output | 1 | One-cycle pulse with each result |
| res_data | output | 24 | Signed, saturated result |
| fast_active | output | 1 | Current result came from the short filter |

## Verification
The assertions check on every cycle the properties that need no arithmetic. These are the single-cycle result pulse, a result word held steady between pulses, a cleared step-tracking flag whenever tracking is gated off, and a flag that can only rise together with a result. They also check a quiet polarity line when chop is off and the cleared outputs after reset. Only the bench scenarios can show the numeric behaviour. That covers the exact sinc3 gain for several bit patterns and ratios, the spacing of results, the slow FIR settling against the immediate bypass path, the length of a short-filter run, offset cancellation under chop, and saturation at both rails.

// File: rtl/dec2_pkg.sv
package dec2_pkg;
    localparam int SINC_W = 26;
    localparam int OUT_W  = 24;
    localparam int COEF_Q = 8;
    localparam int ACC_W  = SINC_W + COEF_Q + 6;
    localparam int SUM_W  = SINC_W + 2;

    typedef logic signed [SINC_W-1:0] samp_t;

    typedef struct packed {
        logic  vld;
        samp_t dat;
    } smp_s;

    // symmetric low-pass taps, the 22 values sum to 2**COEF_Q
    function automatic int fir_coef(input int k);
        int idx;
        idx = (k < 11) ? k : 21 - k;
        case (idx)
            0: return 1;   1: return 2;   2: return 4;   3: return 6;
            4: return 9;   5: return 12;  6: return 15;  7: return 17;
            8: return 19;  9: return 21;  default: return 22;
        endcase
    endfunction

    localparam samp_t SAT_HI = samp_t'((64'sd1 <<< (OUT_W-1)) - 1);
    localparam samp_t SAT_LO = samp_t'(-(64'sd1 <<< (OUT_W-1)));

    function automatic logic signed [OUT_W-1:0] clip_out(input samp_t v);
        if (v > SAT_HI) return SAT_HI[OUT_W-1:0];
        if (v < SAT_LO) return SAT_LO[OUT_W-1:0];
        return v[OUT_W-1:0];
    endfunction
endpackage

// File: rtl/dec2_sinc3.sv
module dec2_sinc3
    import dec2_pkg::*;
#(
    parameter int DEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic [DEC_W-1:0] dec_ratio,
    output smp_s             smp
);
    samp_t acc1, acc2, acc3;
    samp_t dly1, dly2, dly3;
    logic [DEC_W-1:0] cnt;
    logic tick;
    samp_t step_in, c1, c2, c3;

    assign step_in = bit_in ? samp_t'(1) : samp_t'(-1);
    assign c1 = acc3 - dly1;
    assign c2 = c1 - dly2;
    assign c3 = c2 - dly3;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc1 <= '0; acc2 <= '0; acc3 <= '0;
            dly1 <= '0; dly2 <= '0; dly3 <= '0;
            cnt  <= '0; tick <= 1'b0;
            smp  <= '0;
        end else begin
            tick    <= 1'b0;
            smp.vld <= 1'b0;
            if (bit_vld) begin
                acc1 <= acc1 + step_in;
                acc2 <= acc2 + acc1;
                acc3 <= acc3 + acc2;
                if (cnt >= dec_ratio - 1'b1) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (tick) begin
                dly1    <= acc3;
                dly2    <= c1;
                dly3    <= c2;
                smp.dat <= c3;
                smp.vld <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dec2_chop.sv
module dec2_chop
    import dec2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chop_en,
    input  smp_s s_in,
    output smp_s s_out,
    output logic pol
);
    samp_t held;
    logic signed [SINC_W:0] half_diff;

    always_ff @(posedge clk) begin
        if (rst || !chop_en) begin
            pol  <= 1'b0;
            held <= '0;
        end else if (s_in.vld) begin
            pol <= ~pol;
            if (!pol) held <= s_in.dat;
        end
    end

    always_comb begin
        half_diff = ($signed({held[SINC_W-1], held}) -
                     $signed({s_in.dat[SINC_W-1], s_in.dat})) >>> 1;
        if (chop_en) begin
            s_out.vld = s_in.vld && pol;
            s_out.dat = samp_t'(half_diff);
        end else begin
            s_out = s_in;
        end
    end
endmodule

// File: rtl/dec2_fir.sv
module dec2_fir
    import dec2_pkg::*;
#(
    parameter int TAPS = 22
) (
    input  logic                   clk,
    input  logic                   rst,
    input  smp_s                   s_in,
    output samp_t                  fir_y,
    output logic [2:0][SINC_W-1:0] recent
);
    samp_t dl [TAPS-1];
    logic signed [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAPS-1; k++) dl[k] <= '0;
        end else if (s_in.vld) begin
            dl[0] <= s_in.dat;
            for (int k = 1; k < TAPS-1; k++) dl[k] <= dl[k-1];
        end
    end

    always_comb begin
        acc = ACC_W'(s_in.dat) * ACC_W'(fir_coef(0));
        for (int k = 1; k < TAPS; k++)
            acc = acc + ACC_W'(dl[k-1]) * ACC_W'(fir_coef(k));
        acc   = (acc + ACC_W'(1 << (COEF_Q-1))) >>> COEF_Q;
        fir_y = samp_t'(acc);
    end

    genvar g;
    generate
        for (g = 0; g < 3; g++) begin : g_recent
            assign recent[g] = dl[g];
        end
    endgenerate
endmodule

// File: rtl/dec2_stage2.sv
module dec2_stage2
    import dec2_pkg::*;
#(
    parameter int TAPS  = 22,
    parameter int THR_W = 24
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        skip_en,
    input  logic                        fast_en,
    input  logic [THR_W-1:0]            step_thr,
    input  smp_s                        s_in,
    input  samp_t                       fir_y,
    input  logic [2:0][SINC_W-1:0]      recent,
    output logic                        res_valid,
    output logic signed [OUT_W-1:0]     res_data,
    output logic                        fast_active
);
    localparam int CW = $clog2(TAPS + 1) + 1;

    samp_t last;
    logic [CW-1:0] fcnt, ncnt;
    logic signed [SINC_W:0] diff;
    logic [SINC_W:0] mag;
    logic step, use_fast;
    logic [2:0] win;
    logic signed [SUM_W-1:0] sum, avg;
    samp_t pick;

    always_comb begin
        diff = $signed({s_in.dat[SINC_W-1], s_in.dat}) - $signed({last[SINC_W-1], last});
        mag  = diff[SINC_W] ? unsigned'(-diff) : unsigned'(diff);
        step = fast_en && !skip_en && (mag > (SINC_W+1)'(step_thr));
        ncnt = step ? CW'(1) : fcnt + 1'b1;
        use_fast = fast_en && !skip_en && (step || (fast_active && ncnt < CW'(TAPS)));
        win  = (ncnt >= CW'(4)) ? 3'd4 : 3'(ncnt);
        sum  = SUM_W'(s_in.dat);
        if (win > 3'd1) sum = sum + SUM_W'($signed(recent[0]));
        if (win > 3'd2) sum = sum + SUM_W'($signed(recent[1]));
        if (win > 3'd3) sum = sum + SUM_W'($signed(recent[2]));
        case (win)
            3'd2:    avg = sum / SUM_W'(2);
            3'd3:    avg = sum / SUM_W'(3);
            3'd4:    avg = sum / SUM_W'(4);
            default: avg = sum;
        endcase
        if (skip_en)       pick = s_in.dat;
        else if (use_fast) pick = samp_t'(avg);
        else               pick = fir_y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_data    <= '0;
            fast_active <= 1'b0;
            fcnt        <= '0;
            last        <= '0;
        end else begin
            res_valid <= s_in.vld;
            if (!fast_en || skip_en) fast_active <= 1'b0;
            if (s_in.vld) begin
                res_data    <= clip_out(pick);
                last        <= pick;
                fast_active <= use_fast;
                fcnt        <= use_fast ? ncnt : '0;
            end
        end
    end
endmodule

// File: rtl/dec2_chain.sv
module dec2_chain
    import dec2_pkg::*;
#(
    parameter int DEC_W = 8,
    parameter int THR_W = 24,
    parameter int TAPS  = 22
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_vld,
    input  logic                    bit_in,
    input  logic [DEC_W-1:0]        dec_ratio,
    input  logic                    skip_en,
    input  logic                    fast_en,
    input  logic                    chop_en,
    input  logic [THR_W-1:0]        step_thr,
    output logic                    chop_pol,
    output logic                    res_valid,
    output logic signed [OUT_W-1:0] res_data,
    output logic                    fast_active
);
    smp_s sinc_s, mid_s;
    samp_t fir_y;
    logic [2:0][SINC_W-1:0] recent;

    dec2_sinc3 #(.DEC_W(DEC_W)) sinc_i (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .dec_ratio(dec_ratio), .smp(sinc_s)
    );

    dec2_chop chop_i (
        .clk(clk), .rst(rst), .chop_en(chop_en),
        .s_in(sinc_s), .s_out(mid_s), .pol(chop_pol)
    );

    dec2_fir #(.TAPS(TAPS)) fir_i (
        .clk(clk), .rst(rst), .s_in(mid_s), .fir_y(fir_y), .recent(recent)
    );

    dec2_stage2 #(.TAPS(TAPS), .THR_W(THR_W)) out_i (
        .clk(clk), .rst(rst), .skip_en(skip_en), .fast_en(fast_en),
        .step_thr(step_thr), .s_in(mid_s), .fir_y(fir_y), .recent(recent),
        .res_valid(res_valid), .res_data(res_data), .fast_active(fast_active)
    );
endmodule

// File: rtl/dec2_chain_chk.sv
module dec2_chain_chk
    import dec2_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    skip_en,
    input logic                    fast_en,
    input logic                    chop_en,
    input logic                    chop_pol,
    input logic                    res_valid,
    input logic signed [OUT_W-1:0] res_data,
    input logic                    fast_active
);
    p_pulse_once_r11: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    p_hold_data_r11: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res_data));

    p_fast_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (skip_en || !fast_en) |=> !fast_active);

    p_fast_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fast_active) |-> res_valid);

    p_pol_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !chop_en |=> !chop_pol);

    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> (!res_valid && !fast_active && !chop_pol && res_data == '0));
endmodule

bind dec2_chain dec2_chain_chk chk_i (
    .clk(clk), .rst(rst), .skip_en(skip_en), .fast_en(fast_en),
    .chop_en(chop_en), .chop_pol(chop_pol), .res_valid(res_valid),
    .res_data(res_data), .fast_active(fast_active)
);

// File: tb/dec2_chain_tb_top.sv
module dec2_chain_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b1;
    logic bit_in = 1'b0;
    logic [7:0] dec_ratio = 8'd8;
    logic skip_en = 1'b0, fast_en = 1'b0, chop_en = 1'b0;
    logic [23:0] step_thr = '0;
    logic chop_pol, res_valid, fast_active;
    logic signed [23:0] res_data;

    int n_chk = 0;
    int n_fail = 0;
    int pat = 0;
    int unsigned ph = 0;

    dec2_chain dut_i (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .dec_ratio(dec_ratio), .skip_en(skip_en), .fast_en(fast_en),
        .chop_en(chop_en), .step_thr(step_thr), .chop_pol(chop_pol),
        .res_valid(res_valid), .res_data(res_data), .fast_active(fast_active)
    );

    always #10 clk = ~clk;

    // modulator stand-in: 0 ones, 1 zeros, 2 seven ones then a zero, 3 alternating
    initial forever begin
        @(negedge clk);
        ph = ph + 1;
        case (pat)
            0: bit_in = 1'b1;
            1: bit_in = 1'b0;
            2: bit_in = (ph % 8) != 0;
            default: bit_in = ph[0];
        endcase
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start(input int r, input bit sk, input bit fs, input bit ch,
                         input int thr, input int p);
        @(negedge clk);
        rst = 1'b1;
        dec_ratio = 8'(r); skip_en = sk; fast_en = fs; chop_en = ch;
        step_thr = 24'(thr); pat = p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic get_n(input int n, output int d, output bit f);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!res_valid);
        end
        d = res_data;
        f = fast_active;
    endtask

    task automatic gap(output int c);
        int d; bit f;
        get_n(1, d, f);
        c = 0;
        do begin @(negedge clk); c++; end while (!res_valid);
    endtask

    task automatic t_reset();
        start(8, 0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!res_valid && res_data == 0 && !fast_active && !chop_pol, "R12",
            {res_valid, fast_active, chop_pol}, 0);
    endtask

    task automatic t_levels();
        int d; bit f;
        start(8, 0, 0, 0, 0, 0);
        get_n(40, d, f); chk(d == 512, "R1 ones", d, 512);
        pat = 1; get_n(30, d, f); chk(d == -512, "R1 zeros", d, -512);
        pat = 2; get_n(30, d, f); chk(d == 384, "R1 seven-of-eight", d, 384);
        pat = 3; get_n(30, d, f); chk(d == 0, "R1 alternating", d, 0);
    endtask

    task automatic t_ratio();
        int d, c; bit f;
        start(4, 1, 0, 0, 0, 0);
        get_n(8, d, f); chk(d == 64, "R1 R2 ratio 4 level", d, 64);
        gap(c); chk(c == 4, "R2 spacing 4", c, 4);
        start(8, 1, 0, 0, 0, 0);
        gap(c); chk(c == 8, "R2 spacing 8", c, 8);
    endtask

    task automatic t_pulse();
        int d; bit f; int held;
        start(4, 1, 0, 0, 0, 0);
        get_n(6, d, f);
        held = res_data;
        @(negedge clk);
        chk(!res_valid, "R11 pulse width", res_valid, 0);
        @(negedge clk);
        chk(res_data == held, "R11 data held", res_data, held);
    endtask

    task automatic t_fir_vs_skip();
        int d; bit f;
        start(8, 0, 0, 0, 0, 0);
        get_n(40, d, f);
        pat = 1; get_n(5, d, f); chk(d > 0, "R3 FIR still settling", d, 1);
        get_n(25, d, f); chk(d == -512, "R3 FIR settled", d, -512);
        start(8, 1, 0, 0, 0, 0);
        get_n(10, d, f);
        pat = 1; get_n(6, d, f); chk(d == -512, "R4 skip settles", d, -512);
    endtask

    task automatic t_fast();
        int d, run; bit f, seen;
        start(8, 0, 1, 0, 100, 0);
        get_n(40, d, f);
        chk(d == 512 && !f, "R5 settled before step", d, 512);
        pat = 1; seen = 0; run = 0;
        for (int i = 1; i <= 40; i++) begin
            get_n(1, d, f);
            if (f) begin seen = 1; run++; end
            if (i == 10) chk(d == -512 && f, "R6 short filter level", d, -512);
        end
        chk(seen, "R5 step flagged", seen, 1);
        chk(run >= 21 && run <= 30, "R7 run length", run, 21);
        chk(d == -512 && !f, "R7 back on FIR", d, -512);
    endtask

    task automatic t_small_step();
        int d; bit f, seen;
        start(8, 0, 1, 0, 200, 0);
        get_n(40, d, f);
        pat = 2; seen = 0;
        for (int i = 0; i < 40; i++) begin
            get_n(1, d, f);
            if (f) seen = 1;
        end
        chk(!seen, "R8 no step flag", seen, 0);
        chk(d == 384, "R8 level", d, 384);
    endtask

    task automatic t_chop();
        int d, c; bit f, p0;
        start(8, 1, 0, 1, 0, 0);
        get_n(10, d, f); chk(d == 0, "R9 offset cancelled", d, 0);
        gap(c); chk(c == 16, "R9 pair spacing", c, 16);
        p0 = chop_pol;
        do @(negedge clk); while (chop_pol == p0);
        c = 0; p0 = chop_pol;
        do begin @(negedge clk); c++; end while (chop_pol == p0);
        chk(c == 8, "R9 polarity toggle period", c, 8);
    endtask

    task automatic t_sat();
        int d; bit f;
        start(255, 1, 0, 0, 0, 0);
        get_n(6, d, f); chk(d == 8388607, "R10 top rail", d, 8388607);
        pat = 1; get_n(6, d, f); chk(d == -8388608, "R10 bottom rail", d, -8388608);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_levels();
        t_ratio();
        t_pulse();
        t_fir_vs_skip();
        t_fast();
        t_small_step();
        t_chop();
        t_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule